// File: doc/BRIEF.md
# Three-Channel Watchdog Timer Bank

This peripheral holds three watchdog channels behind one small synchronous register port. Each channel owns a 16-bit down-counter and a 16-bit limit register. A shared prescaler turns the system clock into a single-cycle enable every tenth of a second, and a running counter loses one count on each enable. When a counter reaches zero, the channel stops and latches an expired flag. A shared mask register decides whether that expiry has any effect outside the block.

Each channel drives a different action. Channel 0 drives an interrupt level. Channel 1 drives a fixed-length pulse that resets the processor only. Channel 2 drives a fixed-length pulse that resets the whole board. Software starts or restarts a channel by writing its limit. It keeps the channel alive by reading the channel's counter, because that read reloads the counter from the limit. A set mask bit suppresses the action of its channel, but the counter goes on counting.

Top module: `wdog_bank`

## Requirements
- R1: After reset every channel reads as stopped and not expired, every counter and every limit reads 1, the mask reads 0x07, and `irq_o`, `rst_cpu_o` and `rst_board_o` are low.
- R2: A write to a channel's limit register loads both the limit and the counter with the written value. It sets the running bit and clears the expired bit. This holds whether or not the channel was already running.
- R3: A read of a channel's counter returns the count held before the read and reloads the counter from the limit. If a tick arrives in the same cycle, the reload wins. A read of the limit register changes nothing.
- R4: A running counter drops by exactly one on each tick, and a tick comes every `TICK_CYCLES` clocks. A stopped counter holds its value.
- R5: A tick that finds a running counter at 1 or 0 expires the channel. At that point the counter becomes 0, running clears and expired sets. A limit of 0 therefore expires on the first tick. The expired bit stays set until the next limit write.
- R6: The status register returns running in bit 0, expired in bit 1, and zero in bits 15:2. Writes to it are ignored.
- R7: The mask register is at byte address 0x30 and keeps bits 2:0, one bit per channel. All other bits read zero. A set bit suppresses that channel's output action but does not stop its counter.
- R8: `irq_o` is high while channel 0 is expired and its mask bit is clear. It follows a change in either condition one clock later.
- R9: When channel 1 expires while unmasked, `rst_cpu_o` goes high for exactly `RST_PULSE_CYC` clocks. Channel 2 does the same on `rst_board_o`.
- R10: Channel n's registers occupy a 16-byte block at 0x10·n. In each block the counter is at +0x0, the limit at +0x4 and the status at +0x8. Only word-aligned addresses are decoded.
- R11: Read data appears on `bus_rdata` on the clock after the read request. Reads of unmapped or misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Channel 0 interrupt level |
| rst_cpu_o | output | 1 | Channel 1 processor-reset pulse |
| rst_board_o | output | 1 | Channel 2 board-reset pulse |

## Verification
The bench counts exact cycles to pin down the counter-read side effect. A design that did not reload would return a decremented value on the second of two back-to-back reads. A design that let a tick win over the reload would return one less than the limit.

Expiry is checked against a cycle window computed from the limit and the tick period, and that window includes a limit of zero. A design with an off-by-one in the terminal count would land a tick outside the window.

The bench also checks that masking only gates the outputs. The mask is cleared on a channel that has already expired, to show the interrupt is a level and not an event. It also checks that status writes leave the state alone. Finally it counts the pulse length clock by clock, which exposes a stretcher that is one cycle long or short.

// File: rtl/wdog_bank_pkg.sv
package wdog_bank_pkg;
  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int BLK_W  = 2;

  typedef enum logic [1:0] {
    OFS_COUNT  = 2'd0,
    OFS_LIMIT  = 2'd1,
    OFS_STATUS = 2'd2,
    OFS_SPARE  = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int TICK_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else if (div_q == LAST) begin
      div_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_chan.sv
module wdog_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             cnt_rd,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             run_o,
  output logic             exp_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic terminal;
  assign terminal = tick & run_o & (cnt_o <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= ONE;
      lim_o <= ONE;
      run_o <= 1'b0;
      exp_o <= 1'b0;
    end else if (lim_wr) begin
      cnt_o <= wdata;
      lim_o <= wdata;
      run_o <= 1'b1;
      exp_o <= 1'b0;
    end else if (cnt_rd) begin
      cnt_o <= lim_o;
    end else if (terminal) begin
      cnt_o <= '0;
      run_o <= 1'b0;
      exp_o <= 1'b1;
    end else if (tick && run_o) begin
      cnt_o <= cnt_o - ONE;
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] FULL = PW'(PULSE_CYC);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_o <= 1'b0;
    end else if (trig) begin
      left_q  <= FULL;
      pulse_o <= 1'b1;
    end else if (left_q > ONE) begin
      left_q  <= left_q - ONE;
      pulse_o <= 1'b1;
    end else begin
      left_q  <= '0;
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_bank.sv
module wdog_bank
  import wdog_bank_pkg::*;
#(
  parameter int TICK_CYCLES   = 20_000_000,
  parameter int RST_PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_cpu_o,
  output logic              rst_board_o
);
  localparam logic [BLK_W-1:0] MASK_BLK = BLK_W'(NUM_CH);

  logic              tick;
  logic [BLK_W-1:0]  blk;
  logic [1:0]        ofs;
  logic              aligned;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] lim_wr, cnt_rd, run_vec, exp_vec;
  logic [CNT_W-1:0]  cnt_arr [NUM_CH];
  logic [CNT_W-1:0]  lim_arr [NUM_CH];
  logic [NUM_CH-1:0] act_vec;
  logic [DATA_W-1:0] rd_mux;
  logic              mask_wr;

  assign blk     = bus_addr[5:4];
  assign ofs     = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign mask_wr = bus_sel & bus_we & aligned & (blk == MASK_BLK) & (ofs == 2'd0);

  wdog_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign lim_wr[i] = bus_sel & bus_we & aligned & (blk == BLK_W'(i)) & (ofs == OFS_LIMIT);
    assign cnt_rd[i] = bus_sel & ~bus_we & aligned & (blk == BLK_W'(i)) & (ofs == OFS_COUNT);

    wdog_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .tick(tick),
      .lim_wr(lim_wr[i]), .wdata(bus_wdata[CNT_W-1:0]), .cnt_rd(cnt_rd[i]),
      .cnt_o(cnt_arr[i]), .lim_o(lim_arr[i]),
      .run_o(run_vec[i]), .exp_o(exp_vec[i])
    );

    if (i == 0) begin : g_level
      logic irq_q;
      always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= exp_vec[i] & ~mask_q[i];
      end
      assign act_vec[i] = irq_q;
    end else begin : g_pulse
      logic exp_d;
      always_ff @(posedge clk) begin
        if (rst) exp_d <= 1'b0;
        else     exp_d <= exp_vec[i];
      end
      wdog_pulse #(.PULSE_CYC(RST_PULSE_CYC)) u_pulse (
        .clk(clk), .rst(rst),
        .trig(exp_vec[i] & ~exp_d & ~mask_q[i]),
        .pulse_o(act_vec[i])
      );
    end
  end

  assign irq_o       = act_vec[0];
  assign rst_cpu_o   = act_vec[1];
  assign rst_board_o = act_vec[2];

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (mask_wr) mask_q <= bus_wdata[NUM_CH-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (blk == MASK_BLK) begin
        if (ofs == 2'd0) rd_mux = DATA_W'(mask_q);
      end else begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (blk == BLK_W'(i)) begin
            case (ofs)
              OFS_COUNT:  rd_mux = DATA_W'(cnt_arr[i]);
              OFS_LIMIT:  rd_mux = DATA_W'(lim_arr[i]);
              OFS_STATUS: rd_mux = DATA_W'({exp_vec[i], run_vec[i]});
              default:    rd_mux = '0;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/wdog_bank_chk.sv
module wdog_bank_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_o,
  input logic       rst_cpu_o,
  input logic       rst_board_o,
  input logic [2:0] mask_bits,
  input logic [2:0] run_vec,
  input logic [2:0] exp_vec,
  input logic [2:0] lim_wr
);
  // R5: a channel is never running and expired at once
  p_run_exp_excl_r5: assert property (@(posedge clk) disable iff (rst)
    (run_vec & exp_vec) == 3'b000);

  // R5: expired holds until a limit write
  for (genvar i = 0; i < 3; i++) begin : g_sticky
    p_exp_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (exp_vec[i] && !lim_wr[i]) |=> exp_vec[i]);
  end

  // R8: interrupt only rises after channel 0 expired
  p_irq_src_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(exp_vec[0]));

  // R9: processor reset pulse starts right after channel 1 expiry
  p_cpu_src_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_cpu_o) |-> ($past(exp_vec[1]) && !$past(exp_vec[1], 2)));

  // R7: a masked channel 2 never starts a board reset
  p_board_mask_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_board_o) |-> !$past(mask_bits[2]));

  // R2: a limit write leaves the channel running
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    lim_wr[1] |=> (run_vec[1] && !exp_vec[1]));
endmodule

bind wdog_bank wdog_bank_chk u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .rst_cpu_o(rst_cpu_o),
  .rst_board_o(rst_board_o), .mask_bits(mask_q), .run_vec(run_vec),
  .exp_vec(exp_vec), .lim_wr(lim_wr)
);

// File: tb/wdog_bank_tb_top.sv
module wdog_bank_tb_top;
  localparam int N = 4;
  localparam int P = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o, rst_cpu_o, rst_board_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_bank #(.TICK_CYCLES(N), .RST_PULSE_CYC(P)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_cpu_o(rst_cpu_o), .rst_board_o(rst_board_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 6'(a);
    @(negedge clk);
    d = int'(bus_rdata);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // poll status until expired, return number of reads taken
  task automatic poll_exp(input int ch, output int n);
    int s;
    n = 0;
    for (int k = 0; k < 500; k++) begin
      rd(ch * 16 + 8, s);
      n++;
      if (s[1]) break;
    end
  endtask

  task automatic pulse_len(output int hi_main, output int hi_other, input bit board);
    hi_main = 0; hi_other = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (board) begin
        if (rst_board_o) hi_main++;
        if (rst_cpu_o)   hi_other++;
      end else begin
        if (rst_cpu_o)   hi_main++;
        if (rst_board_o) hi_other++;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, n, hm, ho;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 3; c++) begin
      rd(c * 16 + 8, v); chk("R1 status", v, 0);
      rd(c * 16 + 4, v); chk("R1 limit", v, 1);
      rd(c * 16 + 0, v); chk("R1 counter", v, 1);
    end
    rd(6'h30, v); chk("R1 mask", v, 7);
    chk("R1 outputs", {irq_o, rst_cpu_o, rst_board_o}, 0);

    // R4 stopped channel holds
    idle(3 * N);
    rd(6'h10, v); chk("R4 stopped counter", v, 1);

    // R2/R4 counting, R3 reload
    wr(6'h04, 5);
    idle(2 * N);
    rd(6'h00, v); chk("R4 two ticks", v, 3);
    rd(6'h00, v); chk("R3 reload", v, 5);
    rd(6'h04, v); chk("R3 limit read", v, 5);
    rd(6'h04, v); chk("R3 limit read no effect", v, 5);
    rd(6'h08, v); chk("R6 running status", v, 1);

    // R5 expiry window, masked channel 0
    wr(6'h04, 2);
    poll_exp(0, n);
    chk_rng("R5 expiry window", n, N + 2, 2 * N + 1);
    chk("R7 masked irq", irq_o, 0);
    rd(6'h00, v); chk("R5 counter zero", v, 0);
    rd(6'h08, v); chk("R5 status expired", v, 2);
    idle(3 * N);
    rd(6'h00, v); chk("R4 stopped after reload", v, 2);
    rd(6'h08, v); chk("R5 sticky", v, 2);

    // R7 mask readback, R8 level irq on unmask
    wr(6'h30, 16'hFFFF);
    rd(6'h30, v); chk("R7 mask bits", v, 7);
    wr(6'h30, 6);
    @(negedge clk);
    chk("R8 irq level", irq_o, 1);
    wr(6'h04, 9);
    @(negedge clk);
    chk("R8 irq clears", irq_o, 0);
    rd(6'h08, v); chk("R2 restart status", v, 1);

    // R6 status write ignored
    wr(6'h08, 0);
    rd(6'h08, v); chk("R6 write ignored", v, 1);

    // R2 rewrite while running
    wr(6'h04, 3);
    idle(N);
    wr(6'h04, 7);
    rd(6'h00, v); chk("R2 rewrite counter", v, 7);
    rd(6'h04, v); chk("R2 rewrite limit", v, 7);
    wr(6'h30, 7);

    // R9 processor reset pulse
    wr(6'h30, 5);
    wr(6'h14, 2);
    pulse_len(hm, ho, 1'b0);
    chk("R9 cpu pulse width", hm, P);
    chk("R9 board quiet", ho, 0);

    // R9 board reset pulse
    wr(6'h30, 3);
    wr(6'h24, 1);
    pulse_len(hm, ho, 1'b1);
    chk("R9 board pulse width", hm, P);
    chk("R9 cpu quiet", ho, 0);

    // R7 masked channel 1 still counts, no pulse
    wr(6'h30, 7);
    wr(6'h14, 1);
    pulse_len(hm, ho, 1'b0);
    chk("R7 masked no pulse", hm, 0);
    rd(6'h18, v); chk("R7 masked still expires", v, 2);

    // R5 limit zero expires on first tick
    wr(6'h24, 0);
    poll_exp(2, n);
    chk_rng("R5 zero limit", n, 2, N + 1);

    // R10/R11 unmapped and misaligned
    rd(6'h3C, v); chk("R11 unmapped", v, 0);
    rd(6'h0C, v); chk("R10 spare offset", v, 0);
    rd(6'h15, v); chk("R11 misaligned", v, 0);
    rd(6'h24, v); chk("R10 channel 2 limit", v, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule